// File: doc/BRIEF.md
# Dual-Timer Capture/Compare Channel

This block is a single event channel placed beside two free-running timers. Software sets it up through a small register bus. It then works in one of two ways. In capture mode it watches an input pin and records a timer value when a chosen edge arrives. In compare mode it watches a timer until the timer equals a stored value, and then acts on an output pin. A select bit in the control word makes one timer the reference and the other the opposite timer. Captures and compares always use the reference timer.

Captured times go into a time register that has a one-entry spare buffer behind it. Reading the time register returns the oldest capture, and the spare then moves forward. A capture that finds both entries full is an overrun. A policy bit decides whether the new value replaces the spare or is dropped. Either mode can ask for a timer to be cleared: a capture can clear the opposite timer, and a compare match can clear the reference or the opposite timer. Each request is a one-cycle pulse on a per-timer output.

Register map:
- Address 0 is the control word. Its fields are:
  - bit 7: timer select.
  - bit 6: compare enable.
  - bits 5:4: action.
  - bit 3: re-arm.
  - bit 1: reset-opposite.
  - bit 0: overwrite in capture mode, reset-enable in compare mode.
- Address 1 is the compare value.
- Address 2 is the time register. Reading it pops the oldest capture.
- Address 3 is status:
  - bit 0: time register full.
  - bit 1: spare full.
  - bit 2: overrun. Writing 1 to this bit clears it.

Top module: `dual_timer_capcmp`

## Requirements
- R1: After reset the time register and spare are empty, the overrun flag is 0, both timer-reset outputs are 0, the compare pin is 0, and the control word reads back as 0.
- R2: Timer select bit 7 = 0 makes timer_a the reference and timer_b the opposite; bit 7 = 1 swaps them. Captured values and compare matches use only the reference timer.
- R3: In capture mode (bit 6 = 0) the action field picks the edge: 00 none, 01 rising, 10 falling, 11 both. The pin passes through a two-flop synchronizer. The captured reference value is in the time register, and its full flag is set, after the third rising clock edge that follows the pin change.
- R4: Reading address 2 returns the oldest capture. If the spare is full, its value moves into the time register on that read. If the spare is empty, the time register becomes empty.
- R5: A capture that finds both entries full sets the overrun flag. With bit 0 = 0 the new value is dropped. With bit 0 = 1 it replaces the spare.
- R6: The overrun flag stays set until a write to address 3 with bit 2 = 1. A write with bit 2 = 0 leaves it set.
- R7: In capture mode with bit 1 = 1, each captured edge pulses the opposite timer's reset output. With bit 1 = 0 no reset is requested.
- R8: In compare mode (bit 6 = 1) a match, meaning reference timer equals compare value, acts on the compare pin on the next clock edge. The action field selects: 01 toggle, 10 set, 11 clear, 00 no change.
- R9: In compare mode with bit 0 = 1, a match pulses a reset. With bit 1 = 0 the target is the reference timer; with bit 1 = 1 it is the opposite timer. With bit 0 = 0 a match requests no reset.
- R10: A control write arms the compare. With re-arm bit 3 = 0, a match disarms it until the control word is written again. With bit 3 = 1 it stays armed.
- R11: A timer-reset request is a one-cycle pulse on exactly one of the two reset outputs.
- R12: In compare mode, edges on the capture pin record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timer_a | input | TW | First free-running timer value |
| timer_b | input | TW | Second free-running timer value |
| cap_pin | input | 1 | Asynchronous capture input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the time register at address 2) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from the addressed register |
| rst_timer_a | output | 1 | One-cycle reset request for timer_a |
| rst_timer_b | output | 1 | One-cycle reset request for timer_b |
| time_q | output | TW | Time register contents |
| cmp_pin | output | 1 | Compare output pin |
| time_valid | output | 1 | Time register holds unread data |
| spare_valid | output | 1 | Spare buffer holds unread data |
| overrun_flag | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that the reference timer equals the compare value for only one cycle at a time, so a re-armed compare never fires on consecutive cycles. They also assume that capture-pin changes are at least a few cycles apart. The stimulus holds the timers constant while a pin change passes through the synchronizer. It moves the reference timer onto the compare value for a single cycle and then off it again. Each new control word is written only while no match is present.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef struct packed {
    logic       tsel;    // 7: 0 -> timer_a is reference
    logic       cmp_en;  // 6: 1 -> compare mode
    logic [1:0] act;     // 5:4: edge select / pin action
    logic       rearm;   // 3
    logic       rsvd;    // 2: reads 0
    logic       rot;     // 1
    logic       ovw_rt;  // 0
  } ctrl_t;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CMP  = 2'd1,
    A_TIME = 2'd2,
    A_STAT = 2'd3
  } addr_e;

  localparam int STAT_OVR_BIT = 2;

  // one-hot reset target: bit0 = timer_a, bit1 = timer_b
  function automatic logic [1:0] reset_target(input ctrl_t c);
    logic pick_opp;
    logic hit_b;
    pick_opp = c.cmp_en ? c.rot : 1'b1;
    hit_b    = pick_opp ? ~c.tsel : c.tsel;
    return hit_b ? 2'b10 : 2'b01;
  endfunction

  function automatic logic edge_hit(input logic [1:0] act, input logic rise,
                                    input logic fall);
    case (act)
      2'b01:   return rise;
      2'b10:   return fall;
      2'b11:   return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic pin_after(input logic [1:0] act, input logic cur);
    case (act)
      2'b01:   return ~cur;
      2'b10:   return 1'b1;
      2'b11:   return 1'b0;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-1:0], pin};
  end

  assign rise = sr[STAGES-1] & ~sr[STAGES];
  assign fall = ~sr[STAGES-1] & sr[STAGES];
endmodule

// File: rtl/capcmp_capture_buf.sv
module capcmp_capture_buf #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [TW-1:0] cap_val,
  input  logic          pop,
  input  logic          ovw,
  output logic [TW-1:0] time_q,
  output logic          time_full,
  output logic          buf_full,
  output logic          ovr_evt
);
  logic [TW-1:0] buf_q, time_n, buf_n;
  logic          time_full_n, buf_full_n;

  always_comb begin
    time_n      = time_q;
    buf_n       = buf_q;
    time_full_n = time_full;
    buf_full_n  = buf_full;
    ovr_evt     = 1'b0;
    if (pop && time_full) begin
      if (buf_full) begin
        time_n     = buf_q;
        buf_full_n = 1'b0;
      end else begin
        time_full_n = 1'b0;
      end
    end
    if (cap) begin
      if (!time_full_n) begin
        time_n      = cap_val;
        time_full_n = 1'b1;
      end else if (!buf_full_n) begin
        buf_n      = cap_val;
        buf_full_n = 1'b1;
      end else begin
        ovr_evt = 1'b1;
        if (ovw) buf_n = cap_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q    <= '0;
      buf_q     <= '0;
      time_full <= 1'b0;
      buf_full  <= 1'b0;
    end else begin
      time_q    <= time_n;
      buf_q     <= buf_n;
      time_full <= time_full_n;
      buf_full  <= buf_full_n;
    end
  end
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare
  import capcmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          arm_load,
  input  logic          arm_val,
  input  logic          rearm,
  input  logic [1:0]    act,
  input  logic [TW-1:0] ref_time,
  input  logic [TW-1:0] cmp_val,
  output logic          match,
  output logic          pin_q
);
  logic armed;

  assign match = enable && armed && (ref_time == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      if (arm_load)            armed <= arm_val;
      else if (match && !rearm) armed <= 1'b0;
      if (match) pin_q <= pin_after(act, pin_q);
    end
  end
endmodule

// File: rtl/dual_timer_capcmp.sv
module dual_timer_capcmp
  import capcmp_pkg::*;
#(
  parameter int TW          = 16,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    timer_a,
  input  logic [TW-1:0]    timer_b,
  input  logic             cap_pin,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             rst_timer_a,
  output logic             rst_timer_b,
  output logic [TW-1:0]    time_q,
  output logic             cmp_pin,
  output logic             time_valid,
  output logic             spare_valid,
  output logic             overrun_flag
);
  localparam int NTIMERS = 2;

  function automatic logic [BUS_W-1:0] widen(input logic [TW-1:0] v);
    logic [BUS_W-1:0] r;
    r          = '0;
    r[TW-1:0]  = v;
    return r;
  endfunction

  ctrl_t          ctrl_q, ctrl_wv;
  logic [TW-1:0]  cmp_q;
  logic [TW-1:0]  timers [NTIMERS];
  logic [TW-1:0]  ref_time;
  logic           ctrl_wr, cmp_wr, ovr_clr;
  logic           rise, fall;
  // named internal events
  logic           cap_evt, pop_evt, match_evt, ovr_evt, ctrl_rearm, ctrl_cmp;
  logic           rst_req;
  logic [1:0]     rst_tgt;
  logic [NTIMERS-1:0] rst_q;

  assign timers[0] = timer_a;
  assign timers[1] = timer_b;
  assign ref_time  = timers[ctrl_q.tsel];

  assign ctrl_wr = bus_wr && (addr_e'(bus_addr) == A_CTRL);
  assign cmp_wr  = bus_wr && (addr_e'(bus_addr) == A_CMP);
  assign ovr_clr = bus_wr && (addr_e'(bus_addr) == A_STAT) && bus_wdata[STAT_OVR_BIT];
  assign pop_evt = bus_rd && (addr_e'(bus_addr) == A_TIME);

  always_comb begin
    ctrl_wv      = ctrl_t'(bus_wdata[7:0]);
    ctrl_wv.rsvd = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_wv;
      if (cmp_wr)  cmp_q  <= bus_wdata[TW-1:0];
    end
  end

  capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .pin (cap_pin), .rise (rise), .fall (fall)
  );

  assign cap_evt = !ctrl_q.cmp_en && edge_hit(ctrl_q.act, rise, fall);

  capcmp_capture_buf #(.TW(TW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap_evt),
    .cap_val   (ref_time),
    .pop       (pop_evt),
    .ovw       (ctrl_q.ovw_rt),
    .time_q    (time_q),
    .time_full (time_valid),
    .buf_full  (spare_valid),
    .ovr_evt   (ovr_evt)
  );

  capcmp_compare #(.TW(TW)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (ctrl_q.cmp_en),
    .arm_load (ctrl_wr),
    .arm_val  (ctrl_wv.cmp_en),
    .rearm    (ctrl_q.rearm),
    .act      (ctrl_q.act),
    .ref_time (ref_time),
    .cmp_val  (cmp_q),
    .match    (match_evt),
    .pin_q    (cmp_pin)
  );

  assign ctrl_rearm = ctrl_q.rearm;
  assign ctrl_cmp   = ctrl_q.cmp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun_flag <= 1'b0;
    else if (ovr_evt) overrun_flag <= 1'b1;
    else if (ovr_clr) overrun_flag <= 1'b0;
  end

  assign rst_req = (cap_evt && ctrl_q.rot) || (match_evt && ctrl_q.ovw_rt);
  assign rst_tgt = reset_target(ctrl_q);

  for (genvar i = 0; i < NTIMERS; i++) begin : g_rst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q[i] <= 1'b0;
      else        rst_q[i] <= rst_req && rst_tgt[i];
    end
  end

  assign rst_timer_a = rst_q[0];
  assign rst_timer_b = rst_q[1];

  always_comb begin
    bus_rdata = '0;
    case (addr_e'(bus_addr))
      A_CTRL: bus_rdata[7:0] = ctrl_q;
      A_CMP:  bus_rdata = widen(cmp_q);
      A_TIME: bus_rdata = widen(time_q);
      A_STAT: begin
        bus_rdata[0]            = time_valid;
        bus_rdata[1]            = spare_valid;
        bus_rdata[STAT_OVR_BIT] = overrun_flag;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/capcmp_checks.sv
module capcmp_checks #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             rst_timer_a,
  input logic             rst_timer_b,
  input logic             cmp_pin,
  input logic             time_valid,
  input logic             spare_valid,
  input logic             overrun_flag,
  input logic             cap_evt,
  input logic             match_evt,
  input logic             rearm
);
  logic ctrl_write, ovr_clear;
  assign ctrl_write = bus_wr && (bus_addr == 2'd0);
  assign ovr_clear  = bus_wr && (bus_addr == 2'd3) && bus_wdata[2];

  assert_spare_behind_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spare_valid |-> time_valid);

  assert_capture_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> time_valid);

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_flag && !ovr_clear) |=> overrun_flag);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_timer_a && rst_timer_b));

  assert_no_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_evt || match_evt) |=> !(rst_timer_a || rst_timer_b));

  assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !rearm && !ctrl_write) |=> !match_evt);

  assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !match_evt |=> $stable(cmp_pin));
endmodule

bind dual_timer_capcmp capcmp_checks #(.BUS_W(BUS_W)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .rst_timer_a  (rst_timer_a),
  .rst_timer_b  (rst_timer_b),
  .cmp_pin      (cmp_pin),
  .time_valid   (time_valid),
  .spare_valid  (spare_valid),
  .overrun_flag (overrun_flag),
  .cap_evt      (cap_evt),
  .match_evt    (match_evt),
  .rearm        (ctrl_rearm)
);

// File: tb/dual_timer_capcmp_test.sv
`timescale 1ns/1ps
module dual_timer_capcmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_a = '0, timer_b = '0;
  logic        cap_pin = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rst_timer_a, rst_timer_b, cmp_pin, time_valid, spare_valid, overrun_flag;
  logic [15:0] time_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic exp_pin = 1'b0;

  always #4 clk = ~clk;

  dual_timer_capcmp uut (
    .clk(clk), .rst_n(rst_n), .timer_a(timer_a), .timer_b(timer_b), .cap_pin(cap_pin),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_timer_a(rst_timer_a), .rst_timer_b(rst_timer_b),
    .time_q(time_q), .cmp_pin(cmp_pin), .time_valid(time_valid),
    .spare_valid(spare_valid), .overrun_flag(overrun_flag)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // pin change, then wait until the capture is visible (third rising edge)
  task automatic pin_to(input logic v);
    cap_pin = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] ctl(input logic tsel, input logic cen, input logic [1:0] act,
                                      input logic rearm, input logic rot, input logic b0);
    return {8'h00, tsel, cen, act, rearm, 1'b0, rot, b0};
  endfunction

  function automatic logic bench_pin(input logic [1:0] act, input logic cur);
    if (act == 2'd1) return !cur;
    if (act == 2'd2) return 1'b1;
    if (act == 2'd3) return 1'b0;
    return cur;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 time_valid", time_valid, 0);
    check("R1 spare_valid", spare_valid, 0);
    check("R1 overrun", overrun_flag, 0);
    check("R1 resets", {rst_timer_a, rst_timer_b}, 0);
    check("R1 cmp_pin", cmp_pin, 0);
    rd(2'd0, d);
    check("R1 ctrl", d, 0);

    // R2 R3 R7 capture sweep over select, edge action, reset-opposite
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 4; m++)
        for (int r = 0; r < 2; r++) begin
          wr(2'd0, ctl(t[0], 1'b0, m[1:0], 1'b0, r[0], 1'b0));
          for (int s = 0; s < 2; s++) begin
            logic hit;
            logic [15:0] ta, tb;
            ta = 16'h1000 + 16'(t * 256 + m * 16 + r * 4 + s);
            tb = ta ^ 16'h8421;
            timer_a = ta; timer_b = tb;
            hit = (m == 3) || (m == 1 && s == 0) || (m == 2 && s == 1);
            pin_to(s == 0);
            check("R7 rst_timer_a", rst_timer_a, hit && r == 1 && t == 1);
            check("R7 rst_timer_b", rst_timer_b, hit && r == 1 && t == 0);
            rd(2'd3, d);
            check("R3 full flag", d[0], hit);
            check("R11 pulse ends", {rst_timer_a, rst_timer_b}, 0);
            if (hit) begin
              rd(2'd2, d);
              check("R2 captured reference", d, t == 1 ? tb : ta);
              check("R4 emptied", time_valid, 0);
            end
          end
        end

    // R4 R5 R6 ordering and overrun, both policies
    for (int o = 0; o < 2; o++) begin
      wr(2'd0, ctl(1'b0, 1'b0, 2'd3, 1'b0, 1'b0, o[0]));
      timer_a = 16'h0A01; pin_to(1'b1);
      timer_a = 16'h0A02; pin_to(1'b0);
      check("R4 spare filled", spare_valid, 1);
      check("R5 no overrun yet", overrun_flag, 0);
      timer_a = 16'h0A03; pin_to(1'b1);
      check("R5 overrun set", overrun_flag, 1);
      rd(2'd2, d);
      check("R4 oldest first", d, 16'h0A01);
      check("R4 spare moved", {time_valid, spare_valid}, 2'b10);
      rd(2'd2, d);
      check("R5 policy value", d, o == 1 ? 16'h0A03 : 16'h0A02);
      check("R4 drained", time_valid, 0);
      wr(2'd3, 16'h0000);
      check("R6 write 0 keeps", overrun_flag, 1);
      wr(2'd3, 16'h0004);
      check("R6 write 1 clears", overrun_flag, 0);
      wr(2'd0, 16'h0000);
      pin_to(1'b0);
    end

    // R12 compare mode ignores capture pin
    timer_a = 16'h1234; timer_b = 16'h1234;
    wr(2'd1, 16'h0050);
    wr(2'd0, ctl(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0));
    pin_to(1'b1);
    check("R12 no capture rise", time_valid, 0);
    pin_to(1'b0);
    check("R12 no capture fall", time_valid, 0);

    // R8 pin actions
    timer_a = 16'h0051; timer_b = 16'h0099;
    for (int m = 1; m < 4; m++) begin
      wr(2'd0, ctl(1'b0, 1'b1, m[1:0], 1'b1, 1'b0, 1'b0));
      for (int k = 0; k < 2; k++) begin
        timer_a = 16'h0050;
        @(negedge clk);
        exp_pin = bench_pin(m[1:0], exp_pin);
        check("R8 pin action", cmp_pin, exp_pin);
        timer_a = 16'h0051;
        @(negedge clk);
      end
    end

    // R2 opposite timer equal to compare value does nothing
    wr(2'd0, ctl(1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1));
    timer_b = 16'h0050;
    @(negedge clk);
    check("R2 opposite ignored pin", cmp_pin, exp_pin);
    check("R2 opposite ignored reset", {rst_timer_a, rst_timer_b}, 0);
    timer_b = 16'h0099;
    @(negedge clk);

    // R9 R11 compare reset target sweep
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 2; r++)
        for (int e = 0; e < 2; e++) begin
          logic want_b, fire;
          timer_a = 16'h0051; timer_b = 16'h0051;
          @(negedge clk);
          wr(2'd0, ctl(t[0], 1'b1, 2'd0, 1'b1, r[0], e[0]));
          if (t == 0) timer_a = 16'h0050; else timer_b = 16'h0050;
          @(negedge clk);
          fire   = (e == 1);
          want_b = (r == 1) ? (t == 0) : (t == 1);
          check("R9 reset a", rst_timer_a, fire && !want_b);
          check("R9 reset b", rst_timer_b, fire && want_b);
          timer_a = 16'h0051; timer_b = 16'h0051;
          @(negedge clk);
          check("R11 single cycle", {rst_timer_a, rst_timer_b}, 0);
        end

    // R10 disarm and re-arm
    timer_a = 16'h0051; timer_b = 16'h0099;
    wr(2'd0, ctl(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
    for (int k = 0; k < 3; k++) begin
      if (k == 2) wr(2'd0, ctl(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0));
      timer_a = 16'h0050;
      @(negedge clk);
      if (k != 1) exp_pin = !exp_pin;
      check("R10 arm state", cmp_pin, exp_pin);
      timer_a = 16'h0051;
      @(negedge clk);
    end

    finish_run();
  end
endmodule